// File: doc/BRIEF.md
# Receive Buffer Pool Allocator

This block hands out receive buffer addresses from a table of 32-bit entries that a host fills and a receive engine drains. The table is shared by up to four pools. Each pool keeps its own base index, its own current index, a 4-bit upper-address nibble and a sticky busy flag. A pool is a ring of entries that starts at its base and ends at the first entry whose wrap flag is set.

The receive engine asks for a buffer by raising `req_valid` with a pool number. The block looks at the entry under that pool's current index in the same cycle. One clock later it reports either a granted 32-bit address or a busy result.

- On a grant, the entry's valid flag is cleared and the pool index moves on: to the next entry, or back to the base if the entry carried the wrap flag.
- An entry marked for interrupt raises a red-line event when it is granted, telling the host to refill the ring.

The host writes entries through its own port and sets up pools through a configuration port. When a host write and a grant land on the same entry in the same cycle, the host write wins.

Top module: `bufpool_alloc`

## Requirements
- R1: After synchronous reset, `rsp_valid` is 0, every `pool_busy` bit is 0, and every table entry reads as not valid.
- R2: An entry is laid out as follows: bit 31 is the valid flag, bit 30 is the wrap flag, bit 29 is the interrupt flag, bit 28 is ignored, and bits 27:0 are the buffer pointer. A granted address is the pool's 4-bit nibble in bits 31:28 followed by the entry's 28 pointer bits.
- R3: A request that finds a valid entry gives `rsp_ok`=1 and the address one cycle later. That entry then reads as not valid.
- R4: After a grant from an entry without the wrap flag, the pool's current index is the next index.
- R5: After a grant from an entry with the wrap flag, the pool's current index is the pool's base.
- R6: `rsp_redline` is 1 exactly when a grant comes from an entry with the interrupt flag set.
- R7: A request that finds an entry that is not valid gives `rsp_busy`=1, `rsp_ok`=0 and `rsp_addr`=0. It leaves the pool index unchanged and sets that pool's `pool_busy` bit, which stays set.
- R8: Each of the four pools keeps its own index and nibble. A request to one pool never moves another pool's index.
- R9: A configuration write loads the pool's base and nibble, sets its current index to the new base, and clears its `pool_busy` bit.
- R10: A host write to the same entry in the same cycle as a grant from that entry wins. The grant returns the old content, and the entry afterwards holds the host's data, including its valid flag.
- R11: A host write with the valid flag set makes an entry grantable again.
- R12: A request is accepted in every cycle. Each response appears exactly one cycle after its request, with `rsp_pool` equal to the requested pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Pool configuration write strobe |
| cfg_pool | input | 2 | Pool being configured |
| cfg_base | input | 6 | New base index for the pool |
| cfg_msb | input | 4 | Upper address nibble for the pool |
| host_wr_en | input | 1 | Host table write strobe |
| host_wr_idx | input | 6 | Table index being written |
| host_wr_data | input | 32 | Entry content (see R2) |
| req_valid | input | 1 | Allocation request |
| req_pool | input | 2 | Pool the request draws from |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Buffer granted |
| rsp_busy | output | 1 | No valid buffer found (busy event) |
| rsp_redline | output | 1 | Granted entry asked for host service |
| rsp_pool | output | 2 | Pool of this response |
| rsp_addr | output | 32 | Granted buffer address, 0 when busy |
| pool_busy | output | 4 | Sticky per-pool busy flags |

## Verification
A wrong pool index shows on the very next response from that pool, as an address from the wrong entry or as a busy result that should not happen. A valid flag that is not cleared shows only once the ring wraps, as a second grant of the same pointer. The bench therefore drains each ring past its wrap point. A wrong collision priority or a stale flag after a host refill shows on the first request that reaches that entry again. The scenarios drive the engine into exactly those entries.

// File: rtl/bufpool_pkg.sv
// Shared constants for the receive buffer pool allocator.
// Assumes 32-bit table entries with the flag layout fixed below.
package bufpool_pkg;
    localparam int ENTRY_W = 32;
    localparam int PTR_W   = 28;
    localparam int MSB_W   = ENTRY_W - PTR_W;
    localparam int VLD_BIT = 31;
    localparam int WRP_BIT = 30;
    localparam int IRQ_BIT = 29;
endpackage

// File: rtl/bufpool_table.sv
// Entry storage shared by all pools.
// The body (wrap, interrupt, pointer) is written only by the host.
// Valid flags have two writers: the grant path clears one, the host
// sets or clears one. On the same index in the same cycle the host wins.
// Reads are combinational so a decision completes within one cycle.
module bufpool_table #(
    parameter int DEPTH = 64,
    parameter int PTR_W = 28,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int BODY_W = PTR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic [IDX_W-1:0]  hw_idx,
    input  logic              hw_vld,
    input  logic [BODY_W-1:0] hw_body,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [BODY_W-1:0] rd_body
);
    logic [BODY_W-1:0] body_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;

    // Host writes the entry body; no reset is needed since the valid flags guard it.
    always_ff @(posedge clk) begin
        if (hw_en) body_q[hw_idx] <= hw_body;
    end

    // Valid flags: grant clears, host write comes last so it wins a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (clr_en) vld_q[clr_idx] <= 1'b0;
            if (hw_en)  vld_q[hw_idx]  <= hw_vld;
        end
    end

    // Combinational read of the entry under the requesting pool's index.
    always_comb begin
        rd_vld  = vld_q[rd_idx];
        rd_body = body_q[rd_idx];
    end

    a_r11_host_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        hw_en |=> vld_q[$past(hw_idx)] == $past(hw_vld));

    a_r3_grant_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(hw_en && hw_idx == clr_idx)) |=> !vld_q[$past(clr_idx)]);

    a_r10_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && hw_en && hw_idx == clr_idx && hw_vld) |=> vld_q[$past(clr_idx)]);
endmodule

// File: rtl/bufpool_ctx.sv
// Per-pool state: base index, current index, address nibble and busy flag.
// Assumes take and miss are never high together.
// A configuration write overrides a grant or a miss in the same cycle.
module bufpool_ctx #(
    parameter int IDX_W = 6,
    parameter int MSB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [IDX_W-1:0] cfg_base,
    input  logic [MSB_W-1:0] cfg_msb,
    input  logic             take,
    input  logic             wrap_hit,
    input  logic             miss,
    output logic [IDX_W-1:0] cur_idx,
    output logic [MSB_W-1:0] msb,
    output logic             busy_flag
);
    logic [IDX_W-1:0] base_q, cur_q;
    logic [MSB_W-1:0] msb_q;
    logic             busy_q;

    // Configuration registers: base and nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            msb_q  <= '0;
        end else if (cfg_en) begin
            base_q <= cfg_base;
            msb_q  <= cfg_msb;
        end
    end

    // Current index: reload on config, step or wrap on a grant.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cur_q <= '0;
        else if (cfg_en)            cur_q <= cfg_base;
        else if (take && wrap_hit)  cur_q <= base_q;
        else if (take)              cur_q <= cur_q + IDX_W'(1);
    end

    // Sticky busy flag: set by a miss, cleared by reconfiguration.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (cfg_en) busy_q <= 1'b0;
        else if (miss)   busy_q <= 1'b1;
    end

    assign cur_idx   = cur_q;
    assign msb       = msb_q;
    assign busy_flag = busy_q;

    a_r4_step_next: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wrap_hit && !cfg_en) |=> cur_q == $past(cur_q) + IDX_W'(1));

    a_r5_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (take && wrap_hit && !cfg_en) |=> cur_q == $past(base_q));

    a_r7_miss_holds_index: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !cfg_en) |=> (busy_q && cur_q == $past(cur_q)));

    a_r9_config_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cur_q == $past(cfg_base) && !busy_q));
endmodule

// File: rtl/bufpool_alloc.sv
// Receive buffer pool allocator top level.
// Each request is decided in the cycle it is presented and answered
// one clock later. req_pool must name an existing pool.
// Entry layout: [31] valid, [30] wrap, [29] interrupt, [28] ignored,
// [27:0] buffer pointer.
module bufpool_alloc #(
    parameter int NUM_POOLS = 4,
    parameter int DEPTH     = 64,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int POOL_W = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1,
    localparam int PTR_W  = bufpool_pkg::PTR_W,
    localparam int MSB_W  = bufpool_pkg::MSB_W,
    localparam int ENT_W  = bufpool_pkg::ENTRY_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [POOL_W-1:0]    cfg_pool,
    input  logic [IDX_W-1:0]     cfg_base,
    input  logic [MSB_W-1:0]     cfg_msb,
    input  logic                 host_wr_en,
    input  logic [IDX_W-1:0]     host_wr_idx,
    input  logic [ENT_W-1:0]     host_wr_data,
    input  logic                 req_valid,
    input  logic [POOL_W-1:0]    req_pool,
    output logic                 rsp_valid,
    output logic                 rsp_ok,
    output logic                 rsp_busy,
    output logic                 rsp_redline,
    output logic [POOL_W-1:0]    rsp_pool,
    output logic [ENT_W-1:0]     rsp_addr,
    output logic [NUM_POOLS-1:0] pool_busy
);
    import bufpool_pkg::*;

    logic [IDX_W-1:0]   cur_arr [NUM_POOLS];
    logic [MSB_W-1:0]   msb_arr [NUM_POOLS];
    logic [IDX_W-1:0]   rd_idx;
    logic               rd_vld;
    logic [PTR_W+1:0]   rd_body;
    logic               ent_wrap, ent_irq;
    logic [PTR_W-1:0]   ent_ptr;
    logic               hit, miss;
    logic               rsvd_unused;

    assign rsvd_unused = host_wr_data[PTR_W];

    // Pick the current index of the requesting pool.
    assign rd_idx = cur_arr[req_pool];

    bufpool_table #(.DEPTH(DEPTH), .PTR_W(PTR_W)) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_en   (host_wr_en),
        .hw_idx  (host_wr_idx),
        .hw_vld  (host_wr_data[VLD_BIT]),
        .hw_body ({host_wr_data[WRP_BIT], host_wr_data[IRQ_BIT], host_wr_data[PTR_W-1:0]}),
        .clr_en  (hit),
        .clr_idx (rd_idx),
        .rd_idx  (rd_idx),
        .rd_vld  (rd_vld),
        .rd_body (rd_body)
    );

    // Split the read entry and classify the request.
    always_comb begin
        ent_wrap = rd_body[PTR_W+1];
        ent_irq  = rd_body[PTR_W];
        ent_ptr  = rd_body[PTR_W-1:0];
        hit      = req_valid && rd_vld;
        miss     = req_valid && !rd_vld;
    end

    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
        logic sel_req, sel_cfg;
        assign sel_req = (req_pool == POOL_W'(p));
        assign sel_cfg = cfg_wr_en && (cfg_pool == POOL_W'(p));
        bufpool_ctx #(.IDX_W(IDX_W), .MSB_W(MSB_W)) ctx_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_en    (sel_cfg),
            .cfg_base  (cfg_base),
            .cfg_msb   (cfg_msb),
            .take      (hit && sel_req),
            .wrap_hit  (ent_wrap),
            .miss      (miss && sel_req),
            .cur_idx   (cur_arr[p]),
            .msb       (msb_arr[p]),
            .busy_flag (pool_busy[p])
        );
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_ok      <= 1'b0;
            rsp_busy    <= 1'b0;
            rsp_redline <= 1'b0;
            rsp_pool    <= '0;
            rsp_addr    <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_ok      <= hit;
            rsp_busy    <= miss;
            rsp_redline <= hit && ent_irq;
            rsp_pool    <= req_pool;
            rsp_addr    <= hit ? {msb_arr[req_pool], ent_ptr} : '0;
        end
    end

    a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid && rsp_pool == $past(req_pool)));

    a_r7_ok_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_ok, rsp_busy}));

    a_r6_redline_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_redline |-> rsp_ok);

    a_r7_busy_no_address: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_busy |-> (rsp_addr == '0));

    a_r1_quiet_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
endmodule

// File: tb/bufpool_alloc_tb_top.sv
// Directed bench for the buffer pool allocator: one task per scenario.
module bufpool_alloc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [1:0]  cfg_pool;
    logic [5:0]  cfg_base;
    logic [3:0]  cfg_msb;
    logic        host_wr_en;
    logic [5:0]  host_wr_idx;
    logic [31:0] host_wr_data;
    logic        req_valid;
    logic [1:0]  req_pool;
    logic        rsp_valid, rsp_ok, rsp_busy, rsp_redline;
    logic [1:0]  rsp_pool;
    logic [31:0] rsp_addr;
    logic [3:0]  pool_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bufpool_alloc dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_pool(cfg_pool), .cfg_base(cfg_base), .cfg_msb(cfg_msb),
        .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx), .host_wr_data(host_wr_data),
        .req_valid(req_valid), .req_pool(req_pool),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_busy(rsp_busy), .rsp_redline(rsp_redline),
        .rsp_pool(rsp_pool), .rsp_addr(rsp_addr), .pool_busy(pool_busy)
    );

    function automatic logic [31:0] mk(bit v, bit w, bit i, logic [27:0] p);
        return {v, w, i, 1'b0, p};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_rsp(string tag, logic [1:0] pool, bit ok, logic [31:0] addr, bit red);
        chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " rsp_ok"}, 32'(rsp_ok), 32'(ok));
        chk({tag, " rsp_busy"}, 32'(rsp_busy), 32'(!ok));
        chk({tag, " rsp_addr"}, rsp_addr, addr);
        chk({tag, " rsp_redline"}, 32'(rsp_redline), 32'(red));
        chk({tag, " rsp_pool"}, 32'(rsp_pool), 32'(pool));
    endtask

    task automatic hwrite(logic [5:0] idx, logic [31:0] data);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_idx = idx; host_wr_data = data;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic cfg(logic [1:0] pool, logic [5:0] base, logic [3:0] msb);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_pool = pool; cfg_base = base; cfg_msb = msb;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic req_one(string tag, logic [1:0] pool, bit ok, logic [31:0] addr, bit red);
        @(negedge clk);
        req_valid = 1'b1; req_pool = pool;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(tag, pool, ok, addr, red);
    endtask

    // Reset state and a request into an empty table.
    task automatic t_reset_and_empty();
        rst_n = 1'b0;
        cfg_wr_en = 0; cfg_pool = 0; cfg_base = 0; cfg_msb = 0;
        host_wr_en = 0; host_wr_idx = 0; host_wr_data = 0;
        req_valid = 0; req_pool = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 pool_busy after reset", 32'(pool_busy), 32'd0);
        req_one("R1 empty table entry", 2'd0, 1'b0, 32'd0, 1'b0);
        chk("R7 busy flag set", 32'(pool_busy), 32'h1);
        req_one("R7 stays busy", 2'd0, 1'b0, 32'd0, 1'b0);
        cfg(2'd0, 6'd0, 4'hA);
        chk("R9 config clears busy", 32'(pool_busy), 32'h0);
    endtask

    // Drain pool 0 through its wrap, then refill one entry.
    task automatic t_drain_pool0();
        hwrite(6'd0, mk(1, 0, 0, 28'h100) | 32'h1000_0000);
        hwrite(6'd1, mk(1, 0, 0, 28'h101));
        hwrite(6'd2, mk(1, 0, 1, 28'h102));
        hwrite(6'd3, mk(1, 1, 0, 28'h103));
        req_one("R2 R3 bit28 ignored", 2'd0, 1'b1, 32'hA000_0100, 1'b0);
        req_one("R4 next entry", 2'd0, 1'b1, 32'hA000_0101, 1'b0);
        req_one("R6 redline entry", 2'd0, 1'b1, 32'hA000_0102, 1'b1);
        req_one("R4 wrap entry", 2'd0, 1'b1, 32'hA000_0103, 1'b0);
        req_one("R5 R3 back at base consumed", 2'd0, 1'b0, 32'd0, 1'b0);
        chk("R7 busy flag pool0", 32'(pool_busy[0]), 32'd1);
        req_one("R7 index held", 2'd0, 1'b0, 32'd0, 1'b0);
        hwrite(6'd0, mk(1, 0, 0, 28'h200));
        req_one("R11 refilled entry", 2'd0, 1'b1, 32'hA000_0200, 1'b0);
        req_one("R3 entry1 consumed", 2'd0, 1'b0, 32'd0, 1'b0);
    endtask

    // Back-to-back requests interleaved across pools.
    task automatic t_interleave();
        cfg(2'd1, 6'd8, 4'h3);
        cfg(2'd2, 6'd16, 4'h5);
        hwrite(6'd8,  mk(1, 0, 0, 28'h800));
        hwrite(6'd9,  mk(1, 1, 0, 28'h900));
        hwrite(6'd16, mk(1, 1, 1, 28'h1600));
        @(negedge clk);
        req_valid = 1'b1; req_pool = 2'd1;
        @(negedge clk);
        check_rsp("R12 b2b p1 first", 2'd1, 1'b1, 32'h3000_0800, 1'b0);
        req_pool = 2'd2;
        @(negedge clk);
        check_rsp("R8 b2b p2", 2'd2, 1'b1, 32'h5000_1600, 1'b1);
        req_pool = 2'd1;
        @(negedge clk);
        check_rsp("R8 p1 index kept", 2'd1, 1'b1, 32'h3000_0900, 1'b0);
        req_pool = 2'd2;
        @(negedge clk);
        check_rsp("R5 p2 single-entry ring", 2'd2, 1'b0, 32'd0, 1'b0);
        req_pool = 2'd1;
        @(negedge clk);
        check_rsp("R5 p1 wrapped", 2'd1, 1'b0, 32'd0, 1'b0);
        req_valid = 1'b0;
        chk("R7 busy flags p1 p2", 32'(pool_busy[2:1]), 32'h3);
        hwrite(6'd1, mk(1, 0, 0, 28'h300));
        req_one("R8 pool0 untouched", 2'd0, 1'b1, 32'hA000_0300, 1'b0);
    endtask

    // Host write colliding with a grant on the same entry.
    task automatic t_collision();
        cfg(2'd3, 6'd32, 4'hF);
        hwrite(6'd32, mk(1, 0, 0, 28'h320));
        hwrite(6'd33, mk(1, 1, 0, 28'h330));
        @(negedge clk);
        req_valid = 1'b1; req_pool = 2'd3;
        host_wr_en = 1'b1; host_wr_idx = 6'd32; host_wr_data = mk(1, 1, 0, 28'h777);
        @(negedge clk);
        req_valid = 1'b0; host_wr_en = 1'b0;
        check_rsp("R10 old content granted", 2'd3, 1'b1, 32'hF000_0320, 1'b0);
        req_one("R4 p3 second", 2'd3, 1'b1, 32'hF000_0330, 1'b0);
        req_one("R10 host data kept valid", 2'd3, 1'b1, 32'hF000_0777, 1'b0);
        req_one("R5 host wrap to base", 2'd3, 1'b0, 32'd0, 1'b0);
        chk("R7 pool_busy all", 32'(pool_busy), 32'hF);
    endtask

    initial begin
        t_reset_and_empty();
        t_drain_pool0();
        t_interleave();
        t_collision();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule